// File: doc/BRIEF.md
# Radix-4 Tree Magnitude Comparator

This block compares two unsigned operands of equal width and reports which is larger or whether they match. The width is a power of four (4, 16, 64 and so on). The block builds a tree of one-bit cells. Each cell judges a single bit position. Combiners then fold each group of four adjacent cell results into a verdict for a field four times wider. This repeats until one verdict covers the whole operand.

Each node carries an "equal" flag and a "greater" flag. A combiner looks at its four child groups from the most significant group downward. The first group that is not equal decides the result. The tree is pure logic. The three result flags (equal, greater, less) are captured in one output register, so a verdict appears one clock after its operands. The less flag is derived from the other two.

The depth of the tree follows from the width parameter. A width that is not a power of four stops elaboration with an error.

Top module: `radix4_cmp`

## Requirements
- R1: One clock edge after operands are presented with `rst` low, `eq_q` is 1 exactly when `a_in` equals `b_in` in every bit position.
- R2: One clock edge after operands are presented with `rst` low, `gt_q` is 1 exactly when `a_in` is greater than `b_in` as an unsigned number.
- R3: One clock edge after operands are presented with `rst` low, `lt_q` is 1 exactly when neither `eq_q` nor `gt_q` is 1, which is when `a_in` is less than `b_in` as an unsigned number.
- R4: After any clock edge at which `rst` was low, exactly one of `eq_q`, `gt_q`, `lt_q` is 1.
- R5: When the operands differ in their most significant bit, that bit alone decides the result, whatever the lower bits hold.
- R6: When the operands differ only in bit 0, the result follows bit 0: `gt_q` if `a_in[0]` is 1, otherwise `lt_q`.
- R7: The outputs are registered. A change on `a_in` or `b_in` between clock edges leaves `eq_q`, `gt_q` and `lt_q` unchanged until the next rising edge of `clk`.
- R8: A clock edge with `rst` high clears `eq_q`, `gt_q` and `lt_q` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | First unsigned operand |
| b_in | input | WIDTH | Second unsigned operand |
| eq_q | output | 1 | Registered flag: operands equal |
| gt_q | output | 1 | Registered flag: a_in greater than b_in |
| lt_q | output | 1 | Registered flag: a_in less than b_in |

## Verification
The assertions assume that `a_in` and `b_in` hold known 0/1 values at every rising edge where `rst` is low. They also assume that a verdict is only meaningful on the edge after reset has been released. The stimulus changes operands only at the falling edge of the clock, so every rising edge samples a settled, fully defined pair.

The stimulus holds reset for several whole cycles before any comparison starts. It raises reset again later only on the same falling-edge grid.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  typedef struct packed {
    logic eq;
    logic gt;
  } cmp_flags_t;

  // Number of radix-4 levels needed to reach the given width
  function automatic int unsigned tree_levels(input int unsigned width);
    int unsigned w;
    int unsigned n;
    w = 1;
    n = 0;
    while (w < width) begin
      w = w * 4;
      n = n + 1;
    end
    return n;
  endfunction

  // Index of the first node of a tree level in the flat node array
  function automatic int unsigned level_base(input int unsigned width,
                                             input int unsigned lvl);
    int unsigned base;
    int unsigned cnt;
    base = 0;
    cnt  = width;
    for (int unsigned j = 0; j < lvl; j++) begin
      base = base + cnt;
      cnt  = cnt / 4;
    end
    return base;
  endfunction

endpackage

// File: rtl/cmp_leaf.sv
module cmp_leaf
  import cmp_pkg::*;
(
  input  logic       x_bit,
  input  logic       y_bit,
  output cmp_flags_t flags
);

  always_comb begin
    flags.eq = ~(x_bit ^ y_bit);
    flags.gt = x_bit & ~y_bit;
  end

endmodule

// File: rtl/cmp_merge4.sv
module cmp_merge4
  import cmp_pkg::*;
(
  input  cmp_flags_t [3:0] kids,   // index 3 is the most significant group
  output cmp_flags_t       flags
);

  always_comb begin
    flags.eq = kids[3].eq & kids[2].eq & kids[1].eq & kids[0].eq;
    flags.gt = kids[3].gt
             | (kids[3].eq & kids[2].gt)
             | (kids[3].eq & kids[2].eq & kids[1].gt)
             | (kids[3].eq & kids[2].eq & kids[1].eq & kids[0].gt);
  end

endmodule

// File: rtl/cmp_tree.sv
module cmp_tree
  import cmp_pkg::*;
#(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output cmp_flags_t       root
);

  localparam int unsigned LEVELS = tree_levels(WIDTH);
  localparam int unsigned NODES  = (4 * WIDTH - 1) / 3;

  cmp_flags_t nodes [NODES];

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_leaf
      cmp_leaf u_leaf (
        .x_bit (a[i]),
        .y_bit (b[i]),
        .flags (nodes[i])
      );
    end

    for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
      localparam int unsigned SRC  = level_base(WIDTH, l - 1);
      localparam int unsigned DST  = level_base(WIDTH, l);
      localparam int unsigned CNT  = WIDTH / (4 ** l);
      for (genvar n = 0; n < CNT; n++) begin : g_node
        cmp_merge4 u_merge (
          .kids  ({nodes[SRC + 4*n + 3], nodes[SRC + 4*n + 2],
                   nodes[SRC + 4*n + 1], nodes[SRC + 4*n]}),
          .flags (nodes[DST + n])
        );
      end
    end
  endgenerate

  assign root = nodes[NODES - 1];

endmodule

// File: rtl/radix4_cmp.sv
module radix4_cmp
  import cmp_pkg::*;
#(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic             eq_q,
  output logic             gt_q,
  output logic             lt_q
);

  localparam int unsigned LEVELS = tree_levels(WIDTH);

  generate
    if (WIDTH < 4 || (4 ** LEVELS) != WIDTH) begin : g_bad_width
      $error("radix4_cmp: WIDTH must be a power of four");
    end
  endgenerate

  cmp_flags_t verdict;

  cmp_tree #(.WIDTH(WIDTH)) u_tree (
    .a    (a_in),
    .b    (b_in),
    .root (verdict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      eq_q <= 1'b0;
      gt_q <= 1'b0;
      lt_q <= 1'b0;
    end else begin
      eq_q <= verdict.eq;
      gt_q <= verdict.gt;
      lt_q <= ~(verdict.eq | verdict.gt);
    end
  end

  // Tree root against a behavioural compare of the operands
  assert_tree_eq_R1: assert property (@(posedge clk) disable iff (rst)
    verdict.eq == (a_in == b_in));

  assert_tree_gt_R2: assert property (@(posedge clk) disable iff (rst)
    verdict.gt == (a_in > b_in));

  // Registered verdict: exactly one flag after a non-reset edge
  assert_one_flag_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones({eq_q, gt_q, lt_q}) == 1);

  // Less-than output tracks the operands one edge later
  assert_lt_order_R3: assert property (@(posedge clk) disable iff (rst)
    (a_in < b_in) |=> lt_q);

  // Synchronous reset clears the flags
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!eq_q && !gt_q && !lt_q));

endmodule

// File: tb/tb_radix4_cmp.sv
module tb_radix4_cmp;

  localparam int unsigned WIDTH = 64;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [WIDTH-1:0] a_in = '0;
  logic [WIDTH-1:0] b_in = '0;
  logic             eq_q, gt_q, lt_q;

  int unsigned n_run  = 0;
  int unsigned n_fail = 0;
  bit          done   = 1'b0;

  logic e_eq, e_gt, e_lt;

  always #2 clk = ~clk;   // 250 MHz

  radix4_cmp #(.WIDTH(WIDTH)) dut (
    .clk  (clk),
    .rst  (rst),
    .a_in (a_in),
    .b_in (b_in),
    .eq_q (eq_q),
    .gt_q (gt_q),
    .lt_q (lt_q)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {eq,gt,lt} actual=%b expected=%b (a=%h b=%h)",
               req, act, exp, a_in, b_in);
    end
  endtask

  // Drive a pair at the falling edge, check the hold, then the verdict
  task automatic apply(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                       input string req);
    logic [2:0] prev;
    @(negedge clk);
    prev = {eq_q, gt_q, lt_q};
    a_in = a;
    b_in = b;
    #1;
    check("R7 hold", {eq_q, gt_q, lt_q}, prev);
    e_eq = (a == b);
    e_gt = (a > b);
    e_lt = (a < b);
    @(negedge clk);
    check(req, {eq_q, gt_q, lt_q}, {e_eq, e_gt, e_lt});
    n_run++;
    if ($countones({eq_q, gt_q, lt_q}) != 1) begin
      n_fail++;
      $display("FAIL R4: flag count actual=%0d expected=1",
               $countones({eq_q, gt_q, lt_q}));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [WIDTH-1:0] ra, rb;
    repeat (4) @(negedge clk);
    check("R8 reset", {eq_q, gt_q, lt_q}, 3'b000);
    rst = 1'b0;

    apply('0, '0, "R1 zeros");
    apply('1, '1, "R1 ones");
    apply({WIDTH{1'b0}} | 1, '0, "R6 lsb a>b");
    apply('0, {WIDTH{1'b0}} | 1, "R6 lsb a<b");
    apply('1, '1 ^ 1, "R6 lsb ones a>b");
    apply({1'b1, {(WIDTH-1){1'b0}}}, {1'b0, {(WIDTH-1){1'b1}}}, "R5 msb a>b");
    apply({1'b0, {(WIDTH-1){1'b1}}}, {1'b1, {(WIDTH-1){1'b0}}}, "R5 msb a<b");
    apply({1'b1, {(WIDTH-1){1'b0}}}, '0, "R5 msb only a>b");
    apply('0, {1'b1, {(WIDTH-1){1'b0}}}, "R3 msb only a<b");

    for (int i = 0; i < 200; i++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      apply(ra, rb, "R2 random");
    end
    for (int i = 0; i < 200; i++) begin
      ra = {$urandom, $urandom};
      rb = ra ^ ({{(WIDTH-1){1'b0}}, 1'b1} << ($urandom % WIDTH));
      apply(ra, rb, "R3 one-bit diff");
      apply(ra, ra, "R1 random equal");
    end

    // Reset again mid-run with a pending greater verdict
    @(negedge clk);
    a_in = '1;
    b_in = '0;
    rst  = 1'b1;
    @(negedge clk);
    check("R8 mid-run reset", {eq_q, gt_q, lt_q}, 3'b000);
    rst = 1'b0;
    apply('1, '0, "R2 after reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule